// File: doc/BRIEF.md
# Interrupt Register Stacking Sequencer

This sequencer handles the register traffic around interrupt entry and exit for a small 8-bit core. After reset it sets the program counter from a start vector and loads the condition code byte with its masked reset value. When it is asked to save, it captures a snapshot of the register file (program counter, two index registers Y and X, the 16-bit accumulator D and the condition codes) and writes it to a byte-wide stack memory, one byte per clock. When it is asked to restore, it reads the same nine-byte frame back into its register outputs.

The start address comes from a 16-bit vector in memory, read as two bytes on consecutive cycles. The exception is the bootstrap mode, where the program counter is forced to a fixed value and no memory access is made. The stack pointer value comes in with each request. The updated pointer is presented at `sp_out` once the transfer is done. Requests are accepted only while the sequencer is idle and initialised.

Top module: `irq_stack_seq`

## Requirements
- R1: While reset is asserted and until `ready` rises, `ccr_out` equals 0xD0 (bit 7 stop-disable, bit 6 X-mask and bit 4 I-mask set), `ready` is 0 and both done pulses are 0.
- R2: In modes 2'b00, 2'b01 and 2'b11, the first cycle after reset release reads address 0xFFFE and the next cycle reads 0xFFFF. `pc_out` becomes {byte@0xFFFE, byte@0xFFFF}, and `ready` is 1 after the second clock edge.
- R3: In mode 2'b10 (bootstrap), no memory read takes place. `pc_out` becomes 0x0000 and `ready` is 1 after the first clock edge.
- R4: A save writes nine bytes on consecutive cycles. Each byte pre-decrements the pointer, so the writes go to `sp_in`-1 down to `sp_in`-9. The byte order is PC low, PC high, Y low, Y high, X low, X high, D low, D high, CCR, which puts the high byte of each word at the lower address. Afterwards `sp_out` is `sp_in`-9.
- R5: The snapshot is taken in the cycle the save request is accepted. Later changes on the snapshot inputs do not alter the stored frame.
- R6: A restore reads nine bytes upward from `sp_in`, post-incrementing the pointer, in the order CCR, D high, D low, X high, X low, Y high, Y low, PC high, PC low. It loads the register outputs, and afterwards `sp_out` is `sp_in`+9.
- R7: `save_done` or `rest_done` is a one-cycle pulse in the cycle after the last byte transfer. `busy` is 1 from acceptance through the last transfer.
- R8: A save or restore request is ignored while `busy` is 1, which includes the reset vector fetch before `ready`.
- R9: If save and restore are requested in the same idle cycle, the save runs and the restore is dropped.
- R10: The memory port never reads and writes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Operating mode; 2'b10 is bootstrap |
| save_req | input | 1 | Request to save the snapshot |
| rest_req | input | 1 | Request to restore from the stack |
| snap_pc | input | 16 | Program counter snapshot |
| snap_y | input | 16 | Y index snapshot |
| snap_x | input | 16 | X index snapshot |
| snap_d | input | 16 | Accumulator D snapshot |
| snap_ccr | input | 8 | Condition code snapshot |
| sp_in | input | ADDR_W | Stack pointer at request |
| sp_out | output | ADDR_W | Stack pointer after transfer |
| pc_out | output | 16 | Program counter (reset or restored) |
| y_out | output | 16 | Restored Y index |
| x_out | output | 16 | Restored X index |
| d_out | output | 16 | Restored accumulator D |
| ccr_out | output | 8 | Condition codes (reset or restored) |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid in the same cycle |
| busy | output | 1 | Fetching vector or transferring a frame |
| ready | output | 1 | Reset vector fetch complete |
| save_done | output | 1 | One-cycle save completion pulse |
| rest_done | output | 1 | One-cycle restore completion pulse |

## Verification
The bench builds the block with its default parameters: a 16-bit address, the vector at 0xFFFE, a reset condition code of 0xD0 and bootstrap as mode 2'b10. With a full 16-bit address, the top-of-memory vector reads can be checked as exact addresses. The bench memory aliases the low byte of the address, so stack frames placed with a nonzero upper byte show that the pointer arithmetic carries across the full width. The bench also resets in all four modes, which covers both the vector fetch and the forced bootstrap start.

// File: rtl/irq_stack_seq.sv
module irq_stack_seq #(
  parameter int               ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] VEC_ADDR = 16'hFFFE,
  parameter logic [15:0]      BOOT_PC   = 16'h0000,
  parameter logic [7:0]       RESET_CCR = 8'hD0,
  parameter logic [1:0]       BOOT_MODE = 2'b10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              save_req,
  input  logic              rest_req,
  input  logic [15:0]       snap_pc,
  input  logic [15:0]       snap_y,
  input  logic [15:0]       snap_x,
  input  logic [15:0]       snap_d,
  input  logic [7:0]        snap_ccr,
  input  logic [ADDR_W-1:0] sp_in,
  output logic [ADDR_W-1:0] sp_out,
  output logic [15:0]       pc_out,
  output logic [15:0]       y_out,
  output logic [15:0]       x_out,
  output logic [15:0]       d_out,
  output logic [7:0]        ccr_out,
  output logic              mem_re,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              busy,
  output logic              ready,
  output logic              save_done,
  output logic              rest_done
);

  localparam int FRAME_BYTES = 9;
  localparam int FRAME_W     = 8 * FRAME_BYTES;
  localparam int CNT_W       = $clog2(FRAME_BYTES);
  localparam logic [CNT_W-1:0]  LAST    = CNT_W'(FRAME_BYTES - 1);
  localparam logic [CNT_W-1:0]  CNT_ONE = CNT_W'(1);
  localparam logic [ADDR_W-1:0] SP_ONE  = ADDR_W'(1);

  typedef enum logic [1:0] {S_VEC, S_IDLE, S_SAVE, S_REST} st_t;

  st_t                st;
  logic [CNT_W-1:0]   idx;
  logic [FRAME_W-1:0] sv_frame;
  logic [FRAME_W-1:0] rf;

  wire              boot        = (mode == BOOT_MODE);
  wire              last        = (idx == LAST);
  wire              accept_save = (st == S_IDLE) && save_req;
  wire              accept_rest = (st == S_IDLE) && rest_req && !save_req;
  wire [CNT_W-1:0]  ridx        = LAST - idx;

  assign busy      = (st != S_IDLE);
  assign mem_we    = (st == S_SAVE);
  assign mem_re    = (st == S_REST) || ((st == S_VEC) && !boot);
  assign mem_wdata = sv_frame[{idx, 3'b000} +: 8];
  assign {ccr_out, d_out, x_out, y_out, pc_out} = rf;

  always_comb begin
    case (st)
      S_VEC:   mem_addr = VEC_ADDR + ADDR_W'(idx);
      S_SAVE:  mem_addr = sp_out - SP_ONE;
      default: mem_addr = sp_out;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_VEC;
      idx       <= '0;
      rf        <= {RESET_CCR, {(FRAME_W-8){1'b0}}};
      sv_frame  <= '0;
      sp_out    <= '0;
      ready     <= 1'b0;
      save_done <= 1'b0;
      rest_done <= 1'b0;
    end else begin
      save_done <= 1'b0;
      rest_done <= 1'b0;
      case (st)
        S_VEC: begin
          if (boot) begin
            rf[15:0] <= BOOT_PC;
            st       <= S_IDLE;
            ready    <= 1'b1;
            idx      <= '0;
          end else if (idx == '0) begin
            rf[15:8] <= mem_rdata;
            idx      <= CNT_ONE;
          end else begin
            rf[7:0]  <= mem_rdata;
            idx      <= '0;
            st       <= S_IDLE;
            ready    <= 1'b1;
          end
        end
        S_IDLE: begin
          if (accept_save) begin
            sv_frame <= {snap_ccr, snap_d, snap_x, snap_y, snap_pc};
            sp_out   <= sp_in;
            idx      <= '0;
            st       <= S_SAVE;
          end else if (accept_rest) begin
            sp_out   <= sp_in;
            idx      <= '0;
            st       <= S_REST;
          end
        end
        S_SAVE: begin
          sp_out <= sp_out - SP_ONE;
          idx    <= idx + CNT_ONE;
          if (last) begin
            idx       <= '0;
            st        <= S_IDLE;
            save_done <= 1'b1;
          end
        end
        default: begin
          rf[{ridx, 3'b000} +: 8] <= mem_rdata;
          sp_out <= sp_out + SP_ONE;
          idx    <= idx + CNT_ONE;
          if (last) begin
            idx       <= '0;
            st        <= S_IDLE;
            rest_done <= 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/irq_stack_seq_chk.sv
module irq_stack_seq_chk #(
  parameter logic [15:0] BOOT_PC   = 16'h0000,
  parameter logic [7:0]  RESET_CCR = 8'hD0,
  parameter logic [1:0]  BOOT_MODE = 2'b10
) (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  mode,
  input logic        ready,
  input logic        save_done,
  input logic        rest_done,
  input logic        mem_we,
  input logic        mem_re,
  input logic [15:0] pc_out,
  input logic [7:0]  ccr_out
);

  AST_RESET_CCR: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> ccr_out == RESET_CCR); // R1

  AST_BOOT_PC: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ready) && mode == BOOT_MODE) |-> pc_out == BOOT_PC); // R3

  AST_SAVE_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (mem_we || save_done)); // R4

  AST_SAVE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    save_done |=> !save_done); // R7

  AST_REST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rest_done |=> !rest_done); // R7

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (save_done || rest_done) |-> (!mem_we && !mem_re)); // R7

  AST_NO_WRITE_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !mem_we); // R8

  AST_NO_RW: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re)); // R10

endmodule

bind irq_stack_seq irq_stack_seq_chk #(
  .BOOT_PC(BOOT_PC), .RESET_CCR(RESET_CCR), .BOOT_MODE(BOOT_MODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .ready(ready),
  .save_done(save_done), .rest_done(rest_done),
  .mem_we(mem_we), .mem_re(mem_re), .pc_out(pc_out), .ccr_out(ccr_out)
);

// File: tb/irq_stack_seq_test.sv
module irq_stack_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic save_req = 1'b0, rest_req = 1'b0;
  logic [15:0] snap_pc = '0, snap_y = '0, snap_x = '0, snap_d = '0;
  logic [7:0] snap_ccr = '0;
  logic [15:0] sp_in = '0;
  logic [15:0] sp_out, pc_out, y_out, x_out, d_out, mem_addr;
  logic [7:0] ccr_out, mem_wdata, mem_rdata;
  logic mem_re, mem_we, busy, ready, save_done, rest_done;

  int tests = 0, fails = 0;
  bit finished = 0;
  logic [7:0] bmem [0:255];
  logic [15:0] last_waddr = '0;

  always #2 clk = ~clk;

  assign mem_rdata = bmem[mem_addr[7:0]];
  always @(posedge clk) if (mem_we) begin
    bmem[mem_addr[7:0]] <= mem_wdata;
    last_waddr <= mem_addr;
  end

  irq_stack_seq uut (.*);

  localparam logic [87:0] TBL [0:2] = '{
    {16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0, 8'hA5, 16'h0090},
    {16'hFFFF, 16'h0001, 16'h8000, 16'h00FF, 8'h00, 16'h0160},
    {16'h0000, 16'hAAAA, 16'h5555, 16'hC3C3, 8'hFF, 16'h1085}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] m, input logic [7:0] hi, input logic [7:0] lo, input bit poke);
    @(negedge clk);
    rst_n = 0; mode = m;
    bmem[8'hFE] = hi; bmem[8'hFF] = lo;
    repeat (2) @(negedge clk);
    chk(ready == 0 && ccr_out == 8'hD0 && !save_done && !rest_done, "R1 reset state", {ready, ccr_out}, {1'b0, 8'hD0});
    rst_n = 1;
    if (poke) save_req = 1;
    #0;
    if (m == 2'b10) begin
      chk(mem_re == 0, "R3 no vector read", mem_re, 0);
      @(negedge clk);
      chk(ready == 1 && pc_out == 16'h0000, "R3 bootstrap pc", pc_out, 16'h0000);
    end else begin
      chk(mem_re == 1 && mem_addr == 16'hFFFE, "R2 first vector addr", mem_addr, 16'hFFFE);
      @(negedge clk);
      chk(mem_re == 1 && mem_addr == 16'hFFFF && ready == 0, "R2 second vector addr", mem_addr, 16'hFFFF);
      @(negedge clk);
      chk(ready == 1 && pc_out == {hi, lo}, "R2 vector pc", pc_out, {hi, lo});
    end
    chk(ccr_out == 8'hD0, "R1 ccr after init", ccr_out, 8'hD0);
    if (poke) begin
      save_req = 0;
      @(negedge clk);
      chk(busy == 0, "R8 request before ready ignored", busy, 0);
    end
  endtask

  function automatic logic [7:0] sbyte(input logic [71:0] f, input int k);
    logic [15:0] pc, y, x, d; logic [7:0] c;
    {pc, y, x, d, c} = f;
    case (k)
      0: return pc[7:0];  1: return pc[15:8];
      2: return y[7:0];   3: return y[15:8];
      4: return x[7:0];   5: return x[15:8];
      6: return d[7:0];   7: return d[15:8];
      default: return c;
    endcase
  endfunction

  task automatic do_save(input logic [87:0] v, input bit corrupt, input bit poke, input bit both);
    logic [15:0] sp = v[15:0];
    @(negedge clk);
    {snap_pc, snap_y, snap_x, snap_d, snap_ccr} = v[87:16];
    sp_in = sp; save_req = 1; rest_req = both;
    @(negedge clk);
    save_req = 0; rest_req = 0;
    chk(busy == 1 && mem_we == 1, "R7 busy during save", busy, 1);
    if (corrupt) {snap_pc, snap_y, snap_x, snap_d, snap_ccr} = ~v[87:16];
    if (poke) begin rest_req = 1; sp_in = sp + 16'h20; end
    @(negedge clk);
    if (poke) begin rest_req = 0; save_req = 1; end
    @(negedge clk);
    save_req = 0;
    repeat (6) @(negedge clk);
    chk(save_done == 0 && mem_we == 1, "R7 no early done", save_done, 0);
    @(negedge clk);
    chk(save_done == 1 && busy == 0, "R7 save done pulse", save_done, 1);
    for (int k = 0; k < 9; k++)
      chk(bmem[8'(sp - 16'(k) - 16'd1)] == sbyte(v[87:16], k),
          corrupt ? "R5 frame byte" : "R4 frame byte", bmem[8'(sp - 16'(k) - 16'd1)], sbyte(v[87:16], k));
    chk(sp_out == sp - 16'd9 && last_waddr == sp - 16'd9, "R4 sp after save", sp_out, sp - 16'd9);
    @(negedge clk);
    chk(save_done == 0, "R7 save done width", save_done, 0);
    if (poke || both) begin
      @(negedge clk);
      chk(busy == 0 && sp_out == sp - 16'd9, both ? "R9 restore dropped" : "R8 busy request ignored", sp_out, sp - 16'd9);
    end
  endtask

  task automatic do_rest(input logic [15:0] sp, input logic [71:0] exp);
    @(negedge clk);
    sp_in = sp; rest_req = 1;
    @(negedge clk);
    rest_req = 0;
    chk(busy == 1 && mem_re == 1 && mem_addr == sp, "R6 first restore addr", mem_addr, sp);
    repeat (8) @(negedge clk);
    chk(rest_done == 0, "R7 no early restore done", rest_done, 0);
    @(negedge clk);
    chk(rest_done == 1 && busy == 0, "R7 restore done pulse", rest_done, 1);
    chk({pc_out, y_out, x_out, d_out, ccr_out} == exp, "R6 restored regs", {pc_out, ccr_out}, {exp[71:56], exp[7:0]});
    chk(sp_out == sp + 16'd9, "R6 sp after restore", sp_out, sp + 16'd9);
    @(negedge clk);
    chk(rest_done == 0, "R7 restore done width", rest_done, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) bmem[i] = 8'h00;
    do_reset(2'b00, 8'hC1, 8'h3A, 0);
    do_reset(2'b01, 8'h80, 8'h02, 0);
    do_reset(2'b11, 8'h0F, 8'hE7, 1);
    do_reset(2'b10, 8'hAB, 8'hCD, 0);

    foreach (TBL[i]) begin
      do_save(TBL[i], 0, 0, 0);
      do_rest(TBL[i][15:0] - 16'd9, TBL[i][87:16]);
    end

    do_save(TBL[0], 1, 0, 0);
    do_save(TBL[1], 0, 1, 0);
    do_save(TBL[2], 0, 0, 1);

    for (int k = 0; k < 9; k++) bmem[8'h30 + k] = 8'h11 * 8'(k + 1);
    do_rest(16'h0230, {16'h8899, 16'h6677, 16'h4455, 16'h2233, 8'h11});

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule